// File: doc/BRIEF.md
# Platform Power State Sequencer

This block powers a host processor up and down through four resting states: G3 (off), S5 (standby), S3 (suspend) and S0 (run). The transition states between them are named explicitly. The resting states are G3, S5, S3 and S0. The transition states are:

- G3S5
- S5S3, which the block splits into S5S3, PRE, PULSE, PGWAIT and WDTWAIT
- S3S0
- S0S3
- S3S5
- S5G3

The sequencer watches four things from the board: the PMIC power-good line, an AP suspend indicator, an AP watchdog-asserted indicator and two request pulses (forced shutdown and power-on). It drives:

- the main 5 V rail enable
- two always-on rail enables
- an active-low PMIC enable that imitates the PMIC power key
- an active-low system reset to the AP
- an active-low watchdog line to the PMIC

All waits are counted in ticks of a 1 ms strobe, `ms_tick`. The pulse and timeout lengths are parameters.

To bring the system up, the block first presses the PMIC key if power is absent. It then waits for power-good and for the AP to release its watchdog line, and gives the whole step one retry before giving up to G3. To force a shutdown, it holds the PMIC key low until power-good drops. On the way down it keeps track of whether the AP shut itself down, so that the standby state can skip the long press.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset the state is G3, all three rail enables are 0, `pmic_en_n`=1, `sys_rst_n`=0 and `pmic_wdt_n`=1.
- R2: In G3, `pmic_pg`=1 takes the block through S5G3 back to G3 with the 5 V rail kept off; otherwise a `power_on` pulse moves it to G3S5. G3S5 sets the 5 V rail on, releases `pmic_wdt_n` and clears the forced-shutdown flag, then enters S5. `power_on` has no effect in any other state.
- R3: In S5, a recorded AP-initiated shutdown is cleared and the block goes to S5G3 without pressing the PMIC key. With no forced shutdown pending, S5 arms one retry and enters S5S3.
- R4: In S5 with a forced shutdown pending, the block drives `pmic_en_n`=0 and stays in S5 while `pmic_pg`=1; once `pmic_pg`=0 it goes to S5G3.
- R5: S5S3 releases `pmic_en_n`. If `pmic_pg`=0 it waits PULSE_MS ticks in PRE, holds `pmic_en_n`=0 for PULSE_MS ticks in PULSE, then releases it and enters PGWAIT. If `pmic_pg`=1 it enters PGWAIT directly.
- R6: In PGWAIT, `pmic_pg`=1 within PG_TIMEOUT_MS ticks turns both always-on rails on, raises `sys_rst_n` and enters WDTWAIT. In WDTWAIT, `ap_wdt`=0 within WDT_TIMEOUT_MS ticks enters S3.
- R7: When either wait times out and the retry is armed, the retry is consumed and S5S3 starts again. When the retry is already used, the block goes to S5G3. A failed boot therefore shows exactly two PMIC key presses.
- R8: S3 goes to S3S5 when `pmic_pg`=0 or a forced shutdown is pending; otherwise it goes to S3S0 when `ap_suspend`=0. S3S0 enters S0 when `pmic_pg`=1.
- R9: S0 goes to S0S3 when `pmic_pg`=0, `ap_suspend`=1 or a forced shutdown is pending. S0S3 enters S3 on the next cycle. A `force_off` pulse sets the forced-shutdown flag from any state.
- R10: On entry to S3S5, `sys_rst_n` drops and an AP-initiated shutdown is recorded if `pmic_pg`=0. If `ap_wdt` rises within WDT_TIMEOUT_MS ticks, the block turns both always-on rails off and enters S5. On timeout it drives `pmic_wdt_n`=0, turns both rails off and enters S5.
- R11: S5G3 releases `pmic_en_n` when a forced shutdown was pending, turns the 5 V rail off and enters G3.
- R12: If `pmic_pg`=0 while in S3S0, the forced-shutdown flag is set and the block goes to S0S3 instead of S0.
- R13: `state_code` encodes the states as: G3=0, G3S5=1, S5=2, S5S3=3, PRE=4, PULSE=5, PGWAIT=6, WDTWAIT=7, S3=8, S3S0=9, S0=10, S0S3=11, S3S5=12, S5G3=13. No other value occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| pmic_pg | input | 1 | PMIC power-good |
| ap_suspend | input | 1 | AP reports suspend (1 = suspended) |
| ap_wdt | input | 1 | AP watchdog asserted (1 = asserted) |
| force_off | input | 1 | Forced-shutdown request pulse |
| power_on | input | 1 | Power-on request pulse, honoured in G3 |
| rail_5v_en | output | 1 | Main 5 V rail enable |
| rail_a_en | output | 1 | First always-on rail enable |
| rail_b_en | output | 1 | Second always-on rail enable |
| pmic_en_n | output | 1 | Active-low PMIC enable (power key) |
| sys_rst_n | output | 1 | Active-low AP system reset |
| pmic_wdt_n | output | 1 | Active-low watchdog line to the PMIC |
| state_code | output | 4 | Encoded current state |

## Verification
A corrupted state register shows up on `state_code` on the very next cycle as an unexpected or illegal value. Every output is registered together with the state, so a missed or extra output edge appears in the same cycle that the state trace diverges. A wrong forced-shutdown, AP-shutdown or retry flag has no port of its own. It becomes visible only at the next decision that reads it: the number of PMIC key presses in a failed boot, whether S5 holds `pmic_en_n` low, or whether S3 leaves for S3S5. A timer fault shows as a key-press width, or a delay before S5G3, that lies outside a window of one tick on either side.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        ST_G3      = 4'd0,
        ST_G3S5    = 4'd1,
        ST_S5      = 4'd2,
        ST_S5S3    = 4'd3,
        ST_PRE     = 4'd4,
        ST_PULSE   = 4'd5,
        ST_PGWAIT  = 4'd6,
        ST_WDTWAIT = 4'd7,
        ST_S3      = 4'd8,
        ST_S3S0    = 4'd9,
        ST_S0      = 4'd10,
        ST_S0S3    = 4'd11,
        ST_S3S5    = 4'd12,
        ST_S5G3    = 4'd13
    } pwr_state_e;

    typedef struct packed {
        logic rail_main;
        logic rail_aux_a;
        logic rail_aux_b;
        logic pmic_en_n;
        logic sys_rst_n;
        logic pmic_wdt_n;
    } pwr_out_t;

    localparam pwr_out_t OUT_RESET = '{
        rail_main:  1'b0,
        rail_aux_a: 1'b0,
        rail_aux_b: 1'b0,
        pmic_en_n:  1'b1,
        sys_rst_n:  1'b0,
        pmic_wdt_n: 1'b1
    };

    localparam int STATE_LAST = 13;

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ms_tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (ms_tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int PULSE_MS       = 50,
    parameter int PG_TIMEOUT_MS  = 300,
    parameter int WDT_TIMEOUT_MS = 100,
    parameter int TW             = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pmic_pg,
    input  logic          ap_suspend,
    input  logic          ap_wdt,
    input  logic          force_off,
    input  logic          power_on,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output pwr_out_t      out_q,
    output pwr_state_e    state_q
);

    localparam logic [TW-1:0] PULSE_CNT = TW'(PULSE_MS);
    localparam logic [TW-1:0] PG_CNT    = TW'(PG_TIMEOUT_MS);
    localparam logic [TW-1:0] WDT_CNT   = TW'(WDT_TIMEOUT_MS);

    pwr_state_e state_d;
    pwr_out_t   out_d;
    logic       force_q, force_d;
    logic       apdown_q, apdown_d;
    logic       retry_q, retry_d;

    always_comb begin
        state_d  = state_q;
        out_d    = out_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        force_d  = force_q;
        apdown_d = apdown_q;
        retry_d  = retry_q;
        unique case (state_q)
            ST_G3: begin
                if (pmic_pg) begin
                    state_d = ST_S5G3;
                end else if (power_on) begin
                    state_d = ST_G3S5;
                end
            end
            ST_G3S5: begin
                out_d.rail_main  = 1'b1;
                out_d.pmic_wdt_n = 1'b1;
                force_d          = 1'b0;
                state_d          = ST_S5;
            end
            ST_S5: begin
                if (apdown_q) begin
                    apdown_d = 1'b0;
                    state_d  = ST_S5G3;
                end else if (!force_q) begin
                    retry_d = 1'b1;
                    state_d = ST_S5S3;
                end else if (!pmic_pg) begin
                    state_d = ST_S5G3;
                end else begin
                    out_d.pmic_en_n = 1'b0;
                end
            end
            ST_S5S3: begin
                out_d.pmic_en_n = 1'b1;
                tmr_load        = 1'b1;
                if (!pmic_pg) begin
                    tmr_val = PULSE_CNT;
                    state_d = ST_PRE;
                end else begin
                    tmr_val = PG_CNT;
                    state_d = ST_PGWAIT;
                end
            end
            ST_PRE: begin
                if (tmr_expired) begin
                    out_d.pmic_en_n = 1'b0;
                    tmr_load        = 1'b1;
                    tmr_val         = PULSE_CNT;
                    state_d         = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (tmr_expired) begin
                    out_d.pmic_en_n = 1'b1;
                    tmr_load        = 1'b1;
                    tmr_val         = PG_CNT;
                    state_d         = ST_PGWAIT;
                end
            end
            ST_PGWAIT: begin
                if (pmic_pg) begin
                    out_d.rail_aux_a = 1'b1;
                    out_d.rail_aux_b = 1'b1;
                    out_d.sys_rst_n  = 1'b1;
                    tmr_load         = 1'b1;
                    tmr_val          = WDT_CNT;
                    state_d          = ST_WDTWAIT;
                end else if (tmr_expired) begin
                    retry_d = 1'b0;
                    state_d = retry_q ? ST_S5S3 : ST_S5G3;
                end
            end
            ST_WDTWAIT: begin
                if (!ap_wdt) begin
                    state_d = ST_S3;
                end else if (tmr_expired) begin
                    retry_d = 1'b0;
                    state_d = retry_q ? ST_S5S3 : ST_S5G3;
                end
            end
            ST_S3: begin
                if (!pmic_pg || force_q) begin
                    apdown_d        = !pmic_pg;
                    out_d.sys_rst_n = 1'b0;
                    tmr_load        = 1'b1;
                    tmr_val         = WDT_CNT;
                    state_d         = ST_S3S5;
                end else if (!ap_suspend) begin
                    state_d = ST_S3S0;
                end
            end
            ST_S3S0: begin
                if (!pmic_pg) begin
                    force_d = 1'b1;
                    state_d = ST_S0S3;
                end else begin
                    state_d = ST_S0;
                end
            end
            ST_S0: begin
                if (!pmic_pg || force_q || ap_suspend) begin
                    state_d = ST_S0S3;
                end
            end
            ST_S0S3: begin
                state_d = ST_S3;
            end
            ST_S3S5: begin
                if (ap_wdt || tmr_expired) begin
                    if (!ap_wdt) begin
                        out_d.pmic_wdt_n = 1'b0;
                    end
                    out_d.rail_aux_a = 1'b0;
                    out_d.rail_aux_b = 1'b0;
                    state_d          = ST_S5;
                end
            end
            ST_S5G3: begin
                if (force_q) begin
                    out_d.pmic_en_n = 1'b1;
                end
                out_d.rail_main = 1'b0;
                state_d         = ST_G3;
            end
            default: begin
                state_d = ST_G3;
            end
        endcase
        if (force_off) begin
            force_d = 1'b1;
        end
    end

    // State register and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_G3;
            force_q  <= 1'b0;
            apdown_q <= 1'b0;
            retry_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            force_q  <= force_d;
            apdown_q <= apdown_d;
            retry_q  <= retry_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= OUT_RESET;
        end else begin
            out_q <= out_d;
        end
    end

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int PULSE_MS       = 50,
    parameter int PG_TIMEOUT_MS  = 300,
    parameter int WDT_TIMEOUT_MS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       pmic_pg,
    input  logic       ap_suspend,
    input  logic       ap_wdt,
    input  logic       force_off,
    input  logic       power_on,
    output logic       rail_5v_en,
    output logic       rail_a_en,
    output logic       rail_b_en,
    output logic       pmic_en_n,
    output logic       sys_rst_n,
    output logic       pmic_wdt_n,
    output logic [3:0] state_code
);

    localparam int MAX_AB = (PULSE_MS > PG_TIMEOUT_MS) ? PULSE_MS : PG_TIMEOUT_MS;
    localparam int MAX_MS = (MAX_AB > WDT_TIMEOUT_MS) ? MAX_AB : WDT_TIMEOUT_MS;
    localparam int TW     = $clog2(MAX_MS + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    pwr_out_t      outs;
    pwr_state_e    state;

    pwr_seq_timer #(.W(TW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_tick  (ms_tick),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pwr_seq_fsm #(
        .PULSE_MS       (PULSE_MS),
        .PG_TIMEOUT_MS  (PG_TIMEOUT_MS),
        .WDT_TIMEOUT_MS (WDT_TIMEOUT_MS),
        .TW             (TW)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pmic_pg     (pmic_pg),
        .ap_suspend  (ap_suspend),
        .ap_wdt      (ap_wdt),
        .force_off   (force_off),
        .power_on    (power_on),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .out_q       (outs),
        .state_q     (state)
    );

    assign rail_5v_en = outs.rail_main;
    assign rail_a_en  = outs.rail_aux_a;
    assign rail_b_en  = outs.rail_aux_b;
    assign pmic_en_n  = outs.pmic_en_n;
    assign sys_rst_n  = outs.sys_rst_n;
    assign pmic_wdt_n = outs.pmic_wdt_n;
    assign state_code = state;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
    import pwr_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pmic_pg,
    input logic       ap_suspend,
    input logic       rail_5v_en,
    input logic       pmic_en_n,
    input logic       sys_rst_n,
    input logic [3:0] state_code
);

    // R2
    g3s5_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == ST_G3S5 |=> (state_code == ST_S5) && rail_5v_en);

    // R5
    key_press_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == ST_PULSE |-> !pmic_en_n);

    // R6
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> state_code == ST_WDTWAIT);

    // R9
    run_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_S0) && (!pmic_pg || ap_suspend) |=> state_code == ST_S0S3);

    // R11
    standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == ST_S5G3 |=> (state_code == ST_G3) && !rail_5v_en);

    // R12
    resume_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_S3S0) && !pmic_pg |=> state_code == ST_S0S3);

    // R13
    state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code <= 4'(STATE_LAST));

endmodule

bind pwr_seq_top pwr_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pmic_pg    (pmic_pg),
    .ap_suspend (ap_suspend),
    .rail_5v_en (rail_5v_en),
    .pmic_en_n  (pmic_en_n),
    .sys_rst_n  (sys_rst_n),
    .state_code (state_code)
);

// File: tb/test_pwr_seq_top.sv
module test_pwr_seq_top;

    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 4;
    localparam int PGTO       = 10;
    localparam int WDTTO      = 6;
    localparam int DIV        = 3;

    localparam int G3 = 0, G3S5 = 1, S5 = 2, S5S3 = 3, PRE = 4, PULSE_ST = 5;
    localparam int PGWAIT = 6, WDTWAIT = 7, S3 = 8, S3S0 = 9, S0 = 10;
    localparam int S0S3 = 11, S3S5 = 12, S5G3 = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0;
    logic pmic_pg = 1'b0;
    logic ap_suspend = 1'b1;
    logic ap_wdt = 1'b1;
    logic force_off = 1'b0;
    logic power_on = 1'b0;
    logic rail_5v_en, rail_a_en, rail_b_en, pmic_en_n, sys_rst_n, pmic_wdt_n;
    logic [3:0] state_code;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    pwr_seq_top #(
        .PULSE_MS       (PULSE),
        .PG_TIMEOUT_MS  (PGTO),
        .WDT_TIMEOUT_MS (WDTTO)
    ) i_pwr_seq_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .ms_tick    (ms_tick),
        .pmic_pg    (pmic_pg),
        .ap_suspend (ap_suspend),
        .ap_wdt     (ap_wdt),
        .force_off  (force_off),
        .power_on   (power_on),
        .rail_5v_en (rail_5v_en),
        .rail_a_en  (rail_a_en),
        .rail_b_en  (rail_b_en),
        .pmic_en_n  (pmic_en_n),
        .sys_rst_n  (sys_rst_n),
        .pmic_wdt_n (pmic_wdt_n),
        .state_code (state_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc = (tc == DIV - 1) ? 0 : tc + 1;
            ms_tick = (tc == 0);
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_state(input int code, input int lim, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (state_code == code) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic pulse_power_on();
        @(negedge clk);
        power_on = 1'b1;
        @(negedge clk);
        power_on = 1'b0;
    endtask

    task automatic pulse_force_off();
        @(negedge clk);
        force_off = 1'b1;
        @(negedge clk);
        force_off = 1'b0;
    endtask

    // Cold boot from G3 with pmic_pg low, ending in S0
    task automatic t_boot_to_s0();
        bit ok;
        int lo;
        ap_wdt = 1'b1;
        ap_suspend = 1'b1;
        pulse_power_on();
        wait_state(S5, 20, ok);
        chk(ok && rail_5v_en, "R2 G3S5 reaches S5 with 5V rail", rail_5v_en, 1);
        chk(pmic_wdt_n == 1'b1, "R2 pmic_wdt_n released at power-up", pmic_wdt_n, 1);
        wait_state(PRE, 20, ok);
        chk(ok, "R3 S5 without force enters S5S3/PRE", state_code, PRE);
        while (pmic_en_n && state_code == PRE) @(negedge clk);
        lo = 0;
        while (!pmic_en_n && lo < 200) begin
            @(negedge clk);
            lo++;
        end
        chk(lo >= (PULSE - 1) * DIV && lo <= (PULSE + 1) * DIV,
            "R5 key press width in cycles", lo, PULSE * DIV);
        chk(state_code == PGWAIT, "R5 released key enters PGWAIT", state_code, PGWAIT);
        pmic_pg = 1'b1;
        @(negedge clk);
        chk(state_code == WDTWAIT && rail_a_en && rail_b_en && sys_rst_n,
            "R6 power-good turns rails on and releases reset", state_code, WDTWAIT);
        ap_wdt = 1'b0;
        @(negedge clk);
        chk(state_code == S3, "R6 watchdog release enters S3", state_code, S3);
        ap_suspend = 1'b0;
        wait_state(S0, 10, ok);
        chk(ok, "R8 S3 leaves through S3S0 to S0 when not suspended", state_code, S0);
    endtask

    task automatic t_reset();
        chk(state_code == G3, "R1 reset state", state_code, G3);
        chk(!rail_5v_en && !rail_a_en && !rail_b_en, "R1 rails off",
            {rail_5v_en, rail_a_en, rail_b_en}, 0);
        chk(pmic_en_n && !sys_rst_n && pmic_wdt_n, "R1 pmic_en_n/sys_rst_n/pmic_wdt_n",
            {pmic_en_n, sys_rst_n, pmic_wdt_n}, 3'b101);
    endtask

    task automatic t_suspend_resume();
        bit ok;
        ap_suspend = 1'b1;
        @(negedge clk);
        chk(state_code == S0S3, "R9 suspend leaves S0 for S0S3", state_code, S0S3);
        @(negedge clk);
        chk(state_code == S3 && rail_a_en && sys_rst_n, "R9 S0S3 enters S3, rails kept",
            state_code, S3);
        repeat (4) @(negedge clk);
        chk(state_code == S3, "R8 S3 held while suspended", state_code, S3);
        ap_suspend = 1'b0;
        wait_state(S0, 10, ok);
        chk(ok, "R8 resume to S0", state_code, S0);
        pulse_power_on();
        repeat (4) @(negedge clk);
        chk(state_code == S0, "R2 power_on ignored in S0", state_code, S0);
    endtask

    task automatic t_forced_off();
        bit ok;
        pulse_force_off();
        wait_state(S3S5, 10, ok);
        chk(ok && !sys_rst_n, "R10 forced shutdown reaches S3S5 with reset asserted",
            sys_rst_n, 0);
        ap_wdt = 1'b1;
        @(negedge clk);
        chk(state_code == S5 && !rail_a_en && !rail_b_en && pmic_wdt_n,
            "R10 watchdog seen, rails off, S5", state_code, S5);
        repeat (5) @(negedge clk);
        chk(state_code == S5 && !pmic_en_n, "R4 forced S5 holds key low", pmic_en_n, 0);
        pmic_pg = 1'b0;
        @(negedge clk);
        chk(state_code == S5G3, "R4 power-good loss enters S5G3", state_code, S5G3);
        @(negedge clk);
        chk(state_code == G3 && pmic_en_n && !rail_5v_en,
            "R11 S5G3 releases key and turns 5V off", {pmic_en_n, rail_5v_en}, 2'b10);
    endtask

    task automatic t_wdt_timeout();
        bit ok;
        pulse_force_off();
        wait_state(S3S5, 10, ok);
        chk(ok, "R9 force_off from S0 reaches S3S5", state_code, S3S5);
        wait_state(S5, 10 * DIV * WDTTO, ok);
        chk(ok && !pmic_wdt_n && !rail_a_en, "R10 watchdog timeout pulls pmic_wdt_n low",
            pmic_wdt_n, 0);
        pmic_pg = 1'b0;
        wait_state(G3, 10, ok);
        chk(ok && !pmic_wdt_n, "R10 pmic_wdt_n held low in G3", pmic_wdt_n, 0);
        t_boot_to_s0();
    endtask

    task automatic t_ap_shutdown();
        bit ok;
        bit key_low = 1'b0;
        pmic_pg = 1'b0;
        wait_state(S3S5, 10, ok);
        chk(ok && !sys_rst_n, "R10 power loss in S0 reaches S3S5", state_code, S3S5);
        ap_wdt = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!pmic_en_n) key_low = 1'b1;
            if (state_code == G3) break;
        end
        chk(state_code == G3 && !rail_5v_en, "R3 AP shutdown goes straight to G3",
            state_code, G3);
        chk(!key_low, "R3 no key press after AP shutdown", key_low, 0);
    endtask

    task automatic t_g3_glitch();
        bit seen = 1'b0;
        @(negedge clk);
        pmic_pg = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (state_code == S5G3) seen = 1'b1;
        end
        pmic_pg = 1'b0;
        repeat (2) @(negedge clk);
        chk(seen && !rail_5v_en && state_code == G3,
            "R2 unexpected power-good in G3 loops via S5G3", state_code, G3);
    endtask

    task automatic t_boot_fail();
        bit ok;
        int falls = 0;
        bit prev;
        ap_wdt = 1'b1;
        pulse_power_on();
        prev = pmic_en_n;
        ok = 1'b0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (prev && !pmic_en_n) falls++;
            prev = pmic_en_n;
            if (state_code == G3) begin
                ok = 1'b1;
                break;
            end
        end
        chk(ok && !rail_5v_en, "R7 failed boot returns to G3", state_code, G3);
        chk(falls == 2, "R7 key pressed exactly twice", falls, 2);
    endtask

    task automatic t_boot_retry_ok();
        bit ok;
        pulse_power_on();
        wait_state(PGWAIT, 200, ok);
        wait_state(S5S3, 200, ok);
        chk(ok, "R7 first timeout retries S5S3", state_code, S5S3);
        wait_state(PGWAIT, 200, ok);
        pmic_pg = 1'b1;
        @(negedge clk);
        chk(state_code == WDTWAIT, "R7 retry succeeds into WDTWAIT", state_code, WDTWAIT);
        ap_wdt = 1'b0;
        wait_state(S0, 10, ok);
        chk(ok, "R8 retried boot reaches S0", state_code, S0);
    endtask

    task automatic t_resume_fail();
        bit ok;
        ap_suspend = 1'b1;
        wait_state(S3, 10, ok);
        ap_suspend = 1'b0;
        wait_state(S3S0, 10, ok);
        pmic_pg = 1'b0;
        @(negedge clk);
        chk(state_code == S0S3, "R12 missing power-good in S3S0 goes to S0S3",
            state_code, S0S3);
        pmic_pg = 1'b1;
        wait_state(S3S5, 10, ok);
        chk(ok, "R12 forced flag drives S3 to S3S5", state_code, S3S5);
        ap_wdt = 1'b1;
        repeat (4) @(negedge clk);
        chk(state_code == S5 && !pmic_en_n, "R12 forced flag holds key in S5",
            pmic_en_n, 0);
        pmic_pg = 1'b0;
        wait_state(G3, 10, ok);
        chk(ok && pmic_en_n, "R11 forced path ends in G3 with key released", pmic_en_n, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        chk(state_code <= 13 && state_code == G3, "R13 state code in G3", state_code, G3);
        t_g3_glitch();
        t_boot_to_s0();
        t_suspend_resume();
        t_forced_off();
        t_boot_to_s0();
        t_wdt_timeout();
        t_ap_shutdown();
        t_boot_fail();
        t_boot_retry_ok();
        t_resume_fail();
        done = 1'b1;
        report();
        $finish;
    end

endmodule